// File: doc/BRIEF.md
# Received Pause Frame Decoder and Timer

This block watches the receive byte stream of an Ethernet MAC for flow-control frames that ask the local station to stop sending. It parses the first eighteen bytes of each frame: destination address, source address, type, opcode and the 16-bit pause quanta. When the frame ends with good status and every field qualifies, the quanta value is loaded into a down-counter. The transmit-pause output stays high while that counter is non-zero. One quanta is a slot time of 512 bit times. The parameter `BITS_PER_CYCLE` converts slot times into clock cycles: 8 bits per cycle gives 64 cycles per slot.

The receive side is a valid/ready stream of one byte per beat, marked with start-of-frame and end-of-frame. The frame-good flag is sampled on the end-of-frame beat. The block never applies back-pressure: `rx_ready` is low only while reset is held and is high from the first clock after reset. The upstream source may therefore present a byte on any cycle. Control inputs are plain levels: a receive flow-control enable, a unicast-pause enable and the station's 48-bit address.

Top module: `pause_rx_ctrl`

## Requirements
- R1: While `rx_fc_en` is low, no frame loads the timer, and the timer is cleared to zero on the next clock, so `tx_pause` is low.
- R2: A frame whose six destination bytes are 01,80,C2,00,00,01 in wire order qualifies as addressed to this station whether `ucast_pause_en` is set or not.
- R3: A frame whose destination bytes equal `station_addr` qualifies only while `ucast_pause_en` is high. The first destination byte is compared with `station_addr[47:40]` and the last with `station_addr[7:0]`.
- R4: A frame qualifies only if bytes 12–13 hold the type 0x8808 and bytes 14–15 hold the opcode 0x0001, high byte first; any other value rejects it.
- R5: The quanta comes from bytes 16–17, high byte first. The timer is loaded only when `rx_good` is high on the end-of-frame beat and the frame holds at least 18 bytes.
- R6: `pause_remain` shows the quanta two clocks after the end-of-frame beat. It then falls by one every SLOT_CYCLES = 512/BITS_PER_CYCLE clocks, so a quanta of q keeps `tx_pause` high for exactly q·SLOT_CYCLES clocks.
- R7: A qualifying frame that arrives during a pause reloads the timer with its own quanta and restarts the slot count. A quanta of zero ends the pause at once.
- R8: `rx_ready` is high in every cycle after reset. A start-of-frame beat restarts parsing at byte 0, and bytes that arrive outside a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Byte on `rx_data` is valid |
| rx_ready | output | 1 | Block accepts a byte; high whenever out of reset |
| rx_sof | input | 1 | This beat is byte 0 of a frame |
| rx_eof | input | 1 | This beat is the last byte of a frame |
| rx_good | input | 1 | Frame passed checks; sampled on the end-of-frame beat |
| station_addr | input | 48 | Station unicast address, first wire byte in bits 47:40 |
| rx_fc_en | input | 1 | Enables pause decoding and the timer |
| ucast_pause_en | input | 1 | Also accept pause frames sent to `station_addr` |
| tx_pause | output | 1 | Transmitter must hold off |
| pause_remain | output | 16 | Slot times left in the current pause |

## Verification
The bench sweeps quanta values against every combination of destination kind and unicast enable, and times the exact cycle on which the pause ends. A design that is off by one in the prescaler or the load latency fails this timing check, and so does one that matches the address with its bytes reversed. Separate frames test each rejection cause on its own: a wrong type, a wrong opcode, bad status, a 17-byte frame against an 18-byte one, a near-miss address, and bytes sent without a start marker. A design that ignores any single field or flag would start a pause on one of these frames. Further cases reload the timer in mid-pause, end a pause with a zero quanta, and drop the enable during a pause. A design that only counts down to zero, or that keeps the old count when the enable drops, fails these.

// File: rtl/pause_rx_pkg.sv
package pause_rx_pkg;
  localparam logic [47:0] PAUSE_MC_DA  = 48'h0180C2000001;
  localparam logic [15:0] CTRL_ETYPE   = 16'h8808;
  localparam logic [15:0] PAUSE_OPCODE = 16'h0001;
  localparam int unsigned OFS_TYPE     = 12;
  localparam int unsigned OFS_OPCODE   = 14;
  localparam int unsigned OFS_QUANTA   = 16;
  localparam int unsigned HDR_BYTES    = 18;
  localparam int unsigned SLOT_BITS    = 512;
  localparam int unsigned QUANTA_W     = 16;

  typedef struct packed {
    logic                valid;
    logic [QUANTA_W-1:0] quanta;
  } pause_cmd_t;
endpackage

// File: rtl/pause_frame_parser.sv
module pause_frame_parser
  import pause_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        rx_good,
  input  logic [47:0] station_addr,
  input  logic        fc_en,
  input  logic        ucast_en,
  output pause_cmd_t  cmd
);
  localparam int unsigned IDX_W = $clog2(HDR_BYTES + 1);
  localparam logic [IDX_W-1:0] P_TYPE = IDX_W'(OFS_TYPE);
  localparam logic [IDX_W-1:0] P_OPC  = IDX_W'(OFS_OPCODE);
  localparam logic [IDX_W-1:0] P_QNT  = IDX_W'(OFS_QUANTA);
  localparam logic [IDX_W-1:0] P_LAST = IDX_W'(HDR_BYTES - 1);
  localparam logic [IDX_W-1:0] P_SAT  = IDX_W'(HDR_BYTES);

  function automatic logic [7:0] addr_byte(input logic [47:0] a, input logic [IDX_W-1:0] p);
    case (p)
      IDX_W'(0): return a[47:40];
      IDX_W'(1): return a[39:32];
      IDX_W'(2): return a[31:24];
      IDX_W'(3): return a[23:16];
      IDX_W'(4): return a[15:8];
      IDX_W'(5): return a[7:0];
      default:   return 8'h00;
    endcase
  endfunction

  logic [IDX_W-1:0] idx_q, pos;
  logic             in_frame_q;
  logic             mc_q, uc_q, ty_q, op_q;
  logic [7:0]       qhi_q, qlo_q;
  logic             beat, in_da;
  logic             mc_n, uc_n, ty_n, op_n;
  logic [7:0]       qhi_n, qlo_n;
  logic             hit;

  always_comb begin
    beat  = rx_valid && (rx_sof || in_frame_q);
    pos   = rx_sof ? '0 : idx_q;
    in_da = (pos < IDX_W'(6));
    mc_n  = rx_sof ? 1'b1 : mc_q;
    uc_n  = rx_sof ? 1'b1 : uc_q;
    ty_n  = rx_sof ? 1'b1 : ty_q;
    op_n  = rx_sof ? 1'b1 : op_q;
    qhi_n = qhi_q;
    qlo_n = qlo_q;
    if (in_da) begin
      mc_n = mc_n && (rx_data == addr_byte(PAUSE_MC_DA, pos));
      uc_n = uc_n && (rx_data == addr_byte(station_addr, pos));
    end
    if (pos == P_TYPE)       ty_n = ty_n && (rx_data == CTRL_ETYPE[15:8]);
    if (pos == P_TYPE + 1)   ty_n = ty_n && (rx_data == CTRL_ETYPE[7:0]);
    if (pos == P_OPC)        op_n = op_n && (rx_data == PAUSE_OPCODE[15:8]);
    if (pos == P_OPC + 1)    op_n = op_n && (rx_data == PAUSE_OPCODE[7:0]);
    if (pos == P_QNT)        qhi_n = rx_data;
    if (pos == P_QNT + 1)    qlo_n = rx_data;
    hit = (mc_n || (ucast_en && uc_n)) && ty_n && op_n
          && rx_good && (pos >= P_LAST) && fc_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      in_frame_q <= 1'b0;
      mc_q       <= 1'b0;
      uc_q       <= 1'b0;
      ty_q       <= 1'b0;
      op_q       <= 1'b0;
      qhi_q      <= '0;
      qlo_q      <= '0;
      cmd        <= '0;
    end else begin
      cmd.valid <= 1'b0;
      if (beat) begin
        idx_q      <= (pos < P_SAT) ? pos + 1'b1 : pos;
        in_frame_q <= !rx_eof;
        mc_q       <= mc_n;
        uc_q       <= uc_n;
        ty_q       <= ty_n;
        op_q       <= op_n;
        qhi_q      <= qhi_n;
        qlo_q      <= qlo_n;
        if (rx_eof && hit) begin
          cmd.valid  <= 1'b1;
          cmd.quanta <= {qhi_n, qlo_n};
        end
      end
    end
  end

  // R5: a load command is a single-cycle pulse per frame end
  p_single_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.valid |=> !cmd.valid);
  // R1: no load is issued when decoding was disabled on the end beat
  p_no_load_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_en |=> !cmd.valid);
  // R8: a load needs an accepted end-of-frame beat on the previous edge
  p_load_needs_eof_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_eof) |=> !cmd.valid);
endmodule

// File: rtl/pause_slot_prescaler.sv
module pause_slot_prescaler #(
  parameter int unsigned SLOT_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int unsigned CNT_W = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = run && !restart && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (restart || !run)    cnt_q <= '0;
    else if (cnt_q == LAST)      cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // R6: slot ticks are never adjacent
  p_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/pause_quanta_timer.sv
module pause_quanta_timer
  import pause_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fc_en,
  input  pause_cmd_t          cmd,
  input  logic                tick,
  output logic [QUANTA_W-1:0] remain
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    remain <= '0;
    else if (!fc_en)               remain <= '0;
    else if (cmd.valid)            remain <= cmd.quanta;
    else if (tick && remain != 0)  remain <= remain - 1'b1;
  end

  // R1: disabling flow control clears the pause
  p_clear_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_en |=> remain == '0);
  // R7: a load replaces the count with the new quanta
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_en && cmd.valid) |=> remain == $past(cmd.quanta));
  // R6: without a load the count holds or steps down by one
  p_step_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_en && !cmd.valid && remain != '0) |=>
      (remain == $past(remain) || remain == $past(remain) - 1'b1));
  // R6: an idle timer stays idle without a load
  p_idle_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.valid && remain == '0) |=> remain == '0);
endmodule

// File: rtl/pause_rx_ctrl.sv
module pause_rx_ctrl
  import pause_rx_pkg::*;
#(
  parameter int unsigned BITS_PER_CYCLE = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        rx_good,
  input  logic [47:0] station_addr,
  input  logic        rx_fc_en,
  input  logic        ucast_pause_en,
  output logic        tx_pause,
  output logic [15:0] pause_remain
);
  localparam int unsigned SLOT_CYCLES = SLOT_BITS / BITS_PER_CYCLE;

  pause_cmd_t          cmd;
  logic                tick;
  logic [QUANTA_W-1:0] remain;
  logic                ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign rx_ready = ready_q;

  pause_frame_parser u_parser (
    .clk, .rst_n, .rx_data,
    .rx_valid (rx_valid && ready_q),
    .rx_sof, .rx_eof, .rx_good, .station_addr,
    .fc_en    (rx_fc_en),
    .ucast_en (ucast_pause_en),
    .cmd      (cmd)
  );

  pause_slot_prescaler #(.SLOT_CYCLES(SLOT_CYCLES)) u_presc (
    .clk, .rst_n,
    .restart (cmd.valid),
    .run     (remain != '0),
    .tick    (tick)
  );

  pause_quanta_timer u_timer (
    .clk, .rst_n,
    .fc_en  (rx_fc_en),
    .cmd    (cmd),
    .tick   (tick),
    .remain (remain)
  );

  assign pause_remain = remain;
  assign tx_pause     = (remain != '0);

  // R8: the block never stalls the stream once out of reset
  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rx_ready);
endmodule

// File: tb/tb_pause_rx_ctrl.sv
module tb_pause_rx_ctrl;
  localparam int BPC = 64;
  localparam int S   = 512 / BPC;
  localparam logic [47:0] MC = 48'h0180C2000001;
  localparam logic [47:0] ST = 48'h02AABBCCDDEE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_good = 0;
  logic rx_ready, tx_pause;
  logic [47:0] station_addr = ST;
  logic rx_fc_en = 1'b1, ucast_pause_en = 1'b0;
  logic [15:0] pause_remain;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pause_rx_ctrl #(.BITS_PER_CYCLE(BPC)) dut (.*);

  task automatic check(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(int i, logic [47:0] da, logic [15:0] et,
                                       logic [15:0] op, logic [15:0] q);
    if (i < 6) return da[8*(5-i) +: 8];
    if (i < 12) return 8'(8'h10 + i);
    case (i)
      12: return et[15:8];
      13: return et[7:0];
      14: return op[15:8];
      15: return op[7:0];
      16: return q[15:8];
      17: return q[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic send(logic [47:0] da, logic [15:0] et, logic [15:0] op,
                      logic [15:0] q, bit good, int len, bit with_sof, bit with_eof);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = fbyte(i, da, et, op, q);
      rx_sof   = with_sof && (i == 0);
      rx_eof   = with_eof && (i == len - 1);
      rx_good  = good;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_good = 0;
  endtask

  task automatic good_frame(logic [47:0] da, logic [15:0] q);
    send(da, 16'h8808, 16'h0001, q, 1'b1, 60, 1'b1, 1'b1);
  endtask

  // after a send: verifies the whole pause window for quanta q
  task automatic expect_run(string req, int q);
    @(negedge clk);
    check(req, pause_remain, q);
    if (q > 0) begin
      repeat (q * S - 1) @(negedge clk);
      check(req, pause_remain, 1);
      check(req, tx_pause, 1);
      @(negedge clk);
    end
    check(req, pause_remain, 0);
    check(req, tx_pause, 0);
  endtask

  task automatic expect_none(string req);
    @(negedge clk);
    check(req, pause_remain, 0);
    check(req, tx_pause, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("reset", tx_pause, 0);
    check("reset", pause_remain, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", rx_ready, 1);

    // R2 R3 R5 R6 sweep: destination kind x unicast enable x quanta
    for (int u = 0; u < 2; u++) begin
      for (int d = 0; d < 2; d++) begin
        for (int q = 0; q < 6; q++) begin
          ucast_pause_en = u[0];
          good_frame(d == 0 ? MC : ST, 16'(q));
          if (d == 0) expect_run("R2", q);
          else if (u == 1) expect_run("R3", q);
          else expect_none("R3");
        end
      end
    end
    ucast_pause_en = 1'b1;
    good_frame(ST ^ 48'h1, 16'd4);                 expect_none("R3");
    good_frame(48'h0180C2000002, 16'd4);           expect_none("R2");
    // R4 field checks
    send(MC, 16'h8809, 16'h0001, 16'd4, 1, 60, 1, 1); expect_none("R4");
    send(MC, 16'h8808, 16'h0002, 16'd4, 1, 60, 1, 1); expect_none("R4");
    // R5 status and length
    send(MC, 16'h8808, 16'h0001, 16'd4, 0, 60, 1, 1); expect_none("R5");
    send(MC, 16'h8808, 16'h0001, 16'd2, 1, 17, 1, 1); expect_none("R5");
    send(MC, 16'h8808, 16'h0001, 16'h0102, 1, 18, 1, 1);
    @(negedge clk); check("R5", pause_remain, 16'h0102);
    // R7 reload and zero quanta
    good_frame(MC, 16'd3);
    expect_run("R7", 3);
    good_frame(MC, 16'd40);
    repeat (10) @(negedge clk);
    good_frame(MC, 16'd0);
    expect_none("R7");
    // R1 disable
    rx_fc_en = 1'b0;
    good_frame(MC, 16'd5); expect_none("R1");
    rx_fc_en = 1'b1;
    good_frame(MC, 16'd9);
    @(negedge clk); check("R1", pause_remain, 9);
    rx_fc_en = 1'b0;
    @(negedge clk); check("R1", tx_pause, 0);
    rx_fc_en = 1'b1;
    // R8 bytes without start marker ignored; SOF restarts parse
    send(MC, 16'h8808, 16'h0001, 16'd4, 1, 60, 0, 1); expect_none("R8");
    send(ST, 16'h0000, 16'h0000, 16'd0, 1, 9, 1, 0);
    good_frame(MC, 16'd2);
    expect_run("R8", 2);
    check("R8", rx_ready, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule